// File: doc/BRIEF.md
# Group-Constrained Cache Event Counter

This block counts cache activity for one cache cluster. Event sources are laid out as a grid. A group selects the column and a code selects the row. Each grid point is a single-cycle pulse line on the `evt_i` bus.

Software programs a small number of counter slots through a flat register interface. For each slot it writes a 12-bit selection word and then sets the enable bit. A group can feed at most one enabled slot at a time. The block keeps a mask of claimed groups. When an enable asks for a group that is already taken, the enable is refused and a sticky flag is set for that slot. One reserved selection word turns a slot into a free-running cycle counter that takes no group.

Each cluster has its own copy of this block. Combining counts across clusters is done elsewhere. There is no interrupt of any kind.

Top module: `cache_evt_pmu`

## Requirements
- R1: After reset, every register reads zero. This covers all selection words, enable bits, counters, the conflict flags and the claimed-group mask.
- R2: A selection word holds the group in bits [3:0] and the code in bits [11:4]. An enabled slot adds one on each clock edge where event line `group*NUM_CODES+code` is high. Lines of other codes or groups do not change it.
- R3: An enable write to a disabled slot is refused when its group (0 to NUM_GROUPS-1) is already held by another enabled slot. A refused slot stays disabled and does not count. No group is ever held by two enabled slots.
- R4: A refused enable sets bit s of the conflict register for slot s. The bit stays set until software writes 1 to that bit position.
- R5: The claimed-group register has bit g set while an enabled slot holds group g. A granted enable sets the bit on the same edge that sets the enable. A disable clears the bit on the same edge that clears the enable.
- R6: Selection word 0x0FE counts every clock cycle while enabled. It claims no group and is never refused, even when several slots use it.
- R7: A selection word that is not 0x0FE never counts if its group field is NUM_GROUPS or more, or its code field is NUM_CODES or more. A group field of NUM_GROUPS or more also claims no group. A valid group with an out-of-range code still claims its group.
- R8: Writes to the selection word of an enabled slot are ignored.
- R9: Any write to a counter address clears that counter. Counters wrap modulo 2^CTR_W. A disabled slot holds its count.
- R10: Register map. Slot s has its selection word at address 4s, its enable at address 4s+1 (bit 0), and its counter at address 4s+2. The conflict register is at address 4·NUM_SLOTS and the claimed-group register at 4·NUM_SLOTS+1. Reads are combinational, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| evt_i | input | NUM_GROUPS*NUM_CODES | Event pulse lines, index group*NUM_CODES+code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The bench builds the block with four slots, eight groups and sixteen codes, as the default parameters give. It narrows CTR_W to 8 so that a counter wrap is reached with a 259-cycle event burst. With four slots, two slots can contend for one group while two others run as cycle counters at the same time. This exercises refusal, hand-over of a released group, and the exemption for the cycle-count word in a single run.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int CFG_W = 12;
  localparam int GRP_FIELD_W = 4;

  // Selection word that turns a slot into a cycle counter.
  localparam logic [CFG_W-1:0] CYCLE_SEL = 12'h0FE;

  // Register offsets inside one slot's window of four addresses.
  localparam logic [1:0] OFS_SEL  = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_CNT  = 2'd2;

  typedef struct packed {
    logic                   is_cycle;
    logic                   claims;
    logic [GRP_FIELD_W-1:0] grp;
  } evt_sel_t;

endpackage

// File: rtl/pmu_evt_select.sv
module pmu_evt_select
  import pmu_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_CODES  = 16
) (
  input  logic [CFG_W-1:0]                 sel_word,
  input  logic [NUM_GROUPS*NUM_CODES-1:0]  evt_i,
  output evt_sel_t                         sel_o,
  output logic                             hit_o
);

  logic [3:0] grp_f;
  logic [7:0] code_f;
  logic       cyc;
  logic       grp_ok;
  logic       code_ok;
  logic       line;

  assign grp_f  = sel_word[3:0];
  assign code_f = sel_word[11:4];

  always_comb begin
    cyc     = (sel_word == CYCLE_SEL);
    grp_ok  = !cyc && ({28'b0, grp_f} < 32'(NUM_GROUPS));
    code_ok = ({24'b0, code_f} < 32'(NUM_CODES));
  end

  // Pick the addressed grid line without a variable-width index.
  always_comb begin
    line = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int c = 0; c < NUM_CODES; c++) begin
        if (grp_f == 4'(g) && code_f == 8'(c)) begin
          line = evt_i[g*NUM_CODES + c];
        end
      end
    end
  end

  always_comb begin
    sel_o.is_cycle = cyc;
    sel_o.claims   = grp_ok;
    sel_o.grp      = grp_f;
    hit_o          = cyc | (grp_ok & code_ok & line);
  end

endmodule

// File: rtl/pmu_slot.sv
module pmu_slot
  import pmu_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [CFG_W-1:0] sel_wdata,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             cnt_clr,
  input  logic             hit,
  output logic [CFG_W-1:0] sel_o,
  output logic             en_o,
  output logic [CTR_W-1:0] cnt_o
);

  logic [CFG_W-1:0] sel_q;
  logic             en_q;
  logic             en_d;
  logic [CTR_W-1:0] cnt_q;
  logic [CTR_W-1:0] cnt_d;
  logic             sel_ld;
  logic             en_ld;
  logic             cnt_ld;

  // Next-state logic
  always_comb begin
    sel_ld = sel_we & ~en_q;
    en_ld  = en_set | en_clr;
    en_d   = en_set & ~en_clr;
    cnt_ld = cnt_clr | (en_q & hit);
    cnt_d  = cnt_clr ? '0 : cnt_q + CTR_W'(1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (sel_ld) sel_q <= sel_wdata;
      if (en_ld)  en_q  <= en_d;
      if (cnt_ld) cnt_q <= cnt_d;
    end
  end

  assign sel_o = sel_q;
  assign en_o  = en_q;
  assign cnt_o = cnt_q;

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(sel_q)) else $error("selection changed while enabled"); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0)) else $error("counter clear missed"); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_clr) |=> $stable(cnt_q)) else $error("disabled slot moved"); // R9

endmodule

// File: rtl/pmu_group_arb.sv
module pmu_group_arb
  import pmu_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int NUM_GROUPS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_SLOTS)-1:0] req_idx,
  input  logic                         en_req,
  input  logic                         dis_req,
  input  logic                         req_claims,
  input  logic [GRP_FIELD_W-1:0]       req_grp,
  input  logic                         stat_w1c,
  input  logic [NUM_SLOTS-1:0]         w1c_mask,
  output logic                         grant_o,
  output logic [NUM_GROUPS-1:0]        busy_o,
  output logic [NUM_SLOTS-1:0]         conflict_o
);

  localparam int GRP_AW = $clog2(NUM_GROUPS);

  logic [NUM_GROUPS-1:0] busy_q;
  logic [NUM_GROUPS-1:0] busy_d;
  logic [NUM_SLOTS-1:0]  conf_q;
  logic [NUM_SLOTS-1:0]  conf_d;
  logic [GRP_AW-1:0]     g;
  logic                  taken;
  logic                  refuse;
  logic                  busy_ld;
  logic                  conf_ld;
  logic                  unused_grp_hi;

  assign g             = req_grp[GRP_AW-1:0];
  assign unused_grp_hi = ^req_grp;

  // Next-state logic
  always_comb begin
    taken   = req_claims & busy_q[g];
    grant_o = en_req & ~taken;
    refuse  = en_req & taken;

    busy_d = busy_q;
    if (grant_o && req_claims) busy_d[g] = 1'b1;
    if (dis_req && req_claims) busy_d[g] = 1'b0;
    busy_ld = (grant_o | dis_req) & req_claims;

    conf_d = conf_q;
    if (stat_w1c) conf_d = conf_d & ~w1c_mask;
    if (refuse)   conf_d[req_idx] = 1'b1;
    conf_ld = stat_w1c | refuse;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      conf_q <= '0;
    end else begin
      if (busy_ld) busy_q <= busy_d;
      if (conf_ld) conf_q <= conf_d;
    end
  end

  assign busy_o     = busy_q;
  assign conflict_o = conf_q;

  AST_RELEASE_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req && req_claims) |=> !busy_q[$past(g)]) else $error("group not released"); // R5
  AST_CLAIM_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && req_claims) |=> busy_q[$past(g)]) else $error("group not claimed"); // R5

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (conf_q[s] && !(stat_w1c && w1c_mask[s])) |=> conf_q[s])
      else $error("conflict flag dropped"); // R4
  end

endmodule

// File: rtl/cache_evt_pmu.sv
module cache_evt_pmu
  import pmu_pkg::*;
#(
  parameter int NUM_SLOTS  = 4,
  parameter int NUM_GROUPS = 8,
  parameter int NUM_CODES  = 16,
  parameter int CTR_W      = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_GROUPS*NUM_CODES-1:0] evt_i,
  input  logic                            reg_we,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata
);

  localparam int SLOT_AW   = $clog2(NUM_SLOTS);
  localparam int GRP_AW    = $clog2(NUM_GROUPS);
  localparam int STAT_ADDR = NUM_SLOTS * 4;
  localparam int BUSY_ADDR = STAT_ADDR + 1;

  logic                 in_slot;
  logic [SLOT_AW-1:0]   idx;
  logic [1:0]           ofs;
  logic                 sel_wr;
  logic                 ctrl_wr;
  logic                 cnt_wr;
  logic                 stat_w1c;
  logic                 en_req;
  logic                 dis_req;
  logic                 grant;
  logic [NUM_GROUPS-1:0] busy;
  logic [NUM_SLOTS-1:0]  conflict;
  logic [NUM_SLOTS-1:0]  en_q;
  logic [NUM_SLOTS-1:0]  clr;
  logic [CFG_W-1:0]      sel_word [NUM_SLOTS];
  logic [CTR_W-1:0]      cnt      [NUM_SLOTS];
  evt_sel_t              sel      [NUM_SLOTS];
  logic                  unused_wdata;

  assign unused_wdata = ^reg_wdata[31:CFG_W];

  // Address decode
  always_comb begin
    in_slot  = (reg_addr < ADDR_W'(STAT_ADDR));
    idx      = reg_addr[SLOT_AW+1:2];
    ofs      = reg_addr[1:0];
    sel_wr   = reg_we & in_slot & (ofs == OFS_SEL);
    ctrl_wr  = reg_we & in_slot & (ofs == OFS_CTRL);
    cnt_wr   = reg_we & in_slot & (ofs == OFS_CNT);
    stat_w1c = reg_we & (reg_addr == ADDR_W'(STAT_ADDR));
    en_req   = ctrl_wr &  reg_wdata[0] & ~en_q[idx];
    dis_req  = ctrl_wr & ~reg_wdata[0] &  en_q[idx];
  end

  pmu_group_arb #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_idx    (idx),
    .en_req     (en_req),
    .dis_req    (dis_req),
    .req_claims (sel[idx].claims),
    .req_grp    (sel[idx].grp),
    .stat_w1c   (stat_w1c),
    .w1c_mask   (reg_wdata[NUM_SLOTS-1:0]),
    .grant_o    (grant),
    .busy_o     (busy),
    .conflict_o (conflict)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic me;
    logic hit;

    assign me     = (idx == SLOT_AW'(s));
    assign clr[s] = cnt_wr & me;

    pmu_evt_select #(
      .NUM_GROUPS (NUM_GROUPS),
      .NUM_CODES  (NUM_CODES)
    ) u_sel (
      .sel_word (sel_word[s]),
      .evt_i    (evt_i),
      .sel_o    (sel[s]),
      .hit_o    (hit)
    );

    pmu_slot #(
      .CTR_W (CTR_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (sel_wr & me),
      .sel_wdata (reg_wdata[CFG_W-1:0]),
      .en_set    (grant & me),
      .en_clr    (dis_req & me),
      .cnt_clr   (clr[s]),
      .hit       (hit),
      .sel_o     (sel_word[s]),
      .en_o      (en_q[s]),
      .cnt_o     (cnt[s])
    );
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (in_slot) begin
      case (ofs)
        OFS_SEL:  reg_rdata[CFG_W-1:0] = sel_word[idx];
        OFS_CTRL: reg_rdata[0]         = en_q[idx];
        OFS_CNT:  reg_rdata[CTR_W-1:0] = cnt[idx];
        default:  reg_rdata            = '0;
      endcase
    end else if (reg_addr == ADDR_W'(STAT_ADDR)) begin
      reg_rdata[NUM_SLOTS-1:0] = conflict;
    end else if (reg_addr == ADDR_W'(BUSY_ADDR)) begin
      reg_rdata[NUM_GROUPS-1:0] = busy;
    end
  end

  // Ownership as seen from the slots, for the checks below.
  logic [NUM_GROUPS-1:0] held;
  logic [NUM_SLOTS-1:0]  owners [NUM_GROUPS];

  always_comb begin
    held = '0;
    for (int g = 0; g < NUM_GROUPS; g++) owners[g] = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (en_q[s] && sel[s].claims) begin
        held[sel[s].grp[GRP_AW-1:0]]          = 1'b1;
        owners[sel[s].grp[GRP_AW-1:0]][s]     = 1'b1;
      end
    end
  end

  AST_BUSY_MATCHES_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == held) else $error("claimed mask out of step"); // R5

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_chk
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owners[g]) <= 1) else $error("group shared"); // R3
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
    AST_REFUSED_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conflict[s]) |-> !en_q[s]) else $error("refused slot enabled"); // R4
    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[s] && sel[s].is_cycle && !clr[s]) |=> (cnt[s] == $past(cnt[s]) + CTR_W'(1)))
      else $error("cycle count skipped"); // R6
    AST_DEAD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[s] && !sel[s].claims && !sel[s].is_cycle && !clr[s]) |=> $stable(cnt[s]))
      else $error("invalid selection counted"); // R7
  end

endmodule

// File: tb/cache_evt_pmu_tb.sv
module cache_evt_pmu_tb;

  localparam int NS = 4;
  localparam int NG = 8;
  localparam int NC = 16;
  localparam int CW = 8;
  localparam int AW = 8;
  localparam int NV = 47;

  // Vector: {op[1:0], addr[7:0], arg[15:0], req[3:0]}
  // op 0 write, 1 pulse line arg, 2 check read == arg, 3 idle arg cycles
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 8'h00, 16'h031, 4'd0},  // slot0 code3 group1
    {2'd0, 8'h01, 16'h001, 4'd0},
    {2'd2, 8'h11, 16'h002, 4'd5},  // R5 group1 claimed
    {2'd2, 8'h01, 16'h001, 4'd10}, // R10 enable readback
    {2'd1, 8'h00, 16'd19,  4'd0},
    {2'd1, 8'h00, 16'd19,  4'd0},
    {2'd1, 8'h00, 16'd20,  4'd0},  // other code
    {2'd1, 8'h00, 16'd35,  4'd0},  // other group
    {2'd2, 8'h02, 16'h002, 4'd2},  // R2
    {2'd0, 8'h04, 16'h051, 4'd0},  // slot1 group1
    {2'd0, 8'h05, 16'h001, 4'd0},  // refused
    {2'd1, 8'h00, 16'd21,  4'd0},
    {2'd2, 8'h05, 16'h000, 4'd3},  // R3
    {2'd2, 8'h06, 16'h000, 4'd3},  // R3
    {2'd2, 8'h02, 16'h002, 4'd2},  // R2
    {2'd2, 8'h10, 16'h002, 4'd4},  // R4
    {2'd0, 8'h10, 16'h002, 4'd0},
    {2'd2, 8'h10, 16'h000, 4'd4},  // R4 cleared
    {2'd0, 8'h00, 16'h072, 4'd0},  // write to enabled slot
    {2'd2, 8'h00, 16'h031, 4'd8},  // R8
    {2'd0, 8'h01, 16'h000, 4'd0},
    {2'd2, 8'h11, 16'h000, 4'd5},  // R5 released
    {2'd2, 8'h01, 16'h000, 4'd5},
    {2'd0, 8'h05, 16'h001, 4'd0},
    {2'd2, 8'h11, 16'h002, 4'd5},  // R5
    {2'd2, 8'h10, 16'h000, 4'd3},  // R3 no refusal now
    {2'd2, 8'h05, 16'h001, 4'd10}, // R10
    {2'd1, 8'h00, 16'd21,  4'd0},
    {2'd2, 8'h06, 16'h001, 4'd2},  // R2
    {2'd1, 8'h00, 16'd19,  4'd0},
    {2'd2, 8'h02, 16'h002, 4'd9},  // R9 hold when off
    {2'd0, 8'h02, 16'h000, 4'd0},
    {2'd2, 8'h02, 16'h000, 4'd9},  // R9 clear
    {2'd0, 8'h0C, 16'h0A9, 4'd0},  // slot3 group9
    {2'd0, 8'h0D, 16'h001, 4'd0},
    {2'd2, 8'h0D, 16'h001, 4'd7},  // R7
    {2'd2, 8'h11, 16'h002, 4'd7},  // R7 no claim
    {2'd3, 8'h00, 16'd5,   4'd0},
    {2'd2, 8'h0E, 16'h000, 4'd7},  // R7
    {2'd0, 8'h00, 16'h103, 4'd0},  // code16 group3
    {2'd0, 8'h01, 16'h001, 4'd0},
    {2'd2, 8'h11, 16'h00A, 4'd7},  // R7 group still claimed
    {2'd1, 8'h00, 16'd48,  4'd0},
    {2'd2, 8'h02, 16'h000, 4'd7},  // R7
    {2'd0, 8'h01, 16'h000, 4'd0},
    {2'd0, 8'h0D, 16'h000, 4'd0},
    {2'd2, 8'h11, 16'h002, 4'd5}   // R5
  };

  logic              clk;
  logic              rst_n;
  logic [NG*NC-1:0]  evt_i;
  logic              reg_we;
  logic [AW-1:0]     reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;

  int total;
  int fails;
  bit done;

  cache_evt_pmu #(
    .NUM_SLOTS (NS), .NUM_GROUPS (NG), .NUM_CODES (NC), .CTR_W (CW), .ADDR_W (AW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .reg_we (reg_we),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    evt_i[line] = 1'b1;
    @(negedge clk);
    evt_i[line] = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    total++;
    if (v !== exp) begin
      fails++;
      $display("FAIL %s addr %0h actual %0h expected %0h", req, a, v, exp);
    end
  endtask

  task automatic chk_val(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0;
    logic [31:0] a1;
    total = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; evt_i = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every mapped register reads zero after reset
    for (int a = 0; a <= 8'h11; a++) chk(8'(a), 32'h0, "R1");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][29:28])
        2'd0: wr(VEC[i][27:20], {16'h0, VEC[i][19:4]});
        2'd1: pulse(int'(VEC[i][19:4]));
        2'd2: chk(VEC[i][27:20], {16'h0, VEC[i][19:4]}, $sformatf("R%0d", VEC[i][3:0]));
        default: repeat (int'(VEC[i][19:4])) @(negedge clk);
      endcase
    end

    // R6: two cycle-count slots beside a claimed group, no refusal
    wr(8'h08, 32'h0FE); wr(8'h09, 32'h1);
    wr(8'h0C, 32'h0FE); wr(8'h0D, 32'h1);
    chk(8'h0D, 32'h1, "R6");
    chk(8'h10, 32'h0, "R6");
    chk(8'h11, 32'h2, "R6");
    rd(8'h0A, a0);
    repeat (20) @(negedge clk);
    rd(8'h0A, a1);
    chk_val({24'h0, 8'(a1 - a0)}, 32'd20, "R6");

    // R9: wrap modulo 2^CTR_W with a 259-cycle burst on line 0
    wr(8'h00, 32'h000); wr(8'h01, 32'h1);
    @(negedge clk);
    evt_i[0] = 1'b1;
    repeat (259) @(negedge clk);
    evt_i[0] = 1'b0;
    chk(8'h02, 32'd3, "R9");

    // R1: asynchronous reset clears state mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(8'h0A, 32'h0, "R1");
    chk(8'h11, 32'h0, "R1");
    chk(8'h09, 32'h0, "R1");
    chk(8'h04, 32'h0, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule